// File: doc/BRIEF.md
# Lap Capture History and Display Window

This block sits beside a stopwatch counter. It takes the live ten-digit time, which holds days, hours, minutes, seconds and hundredths with two BCD digits each, and keeps lap snapshots of it. Each press of a record pushbutton stores one snapshot. The block keeps the four newest snapshots, with the newest always at the front.

It also picks what a four-digit display shows. A view switch chooses between the live time and one stored lap. A two-bit lap selector picks which stored lap is shown. A two-bit range selector picks two adjacent time fields to fill the four digits. All selectors are registered before use. The counter that produces the time and the segment scan driver are outside this block.

Top module: `lap_view_top`

## Requirements
- R1: The record button passes through two sampling registers. When the newer sample is 1 and the older one is 0, `capture_o` is high for exactly one clock cycle. Holding the button or releasing it produces no further pulse.
- R2: A capture pulse stores the value on `live_time_i` at that clock edge as the newest lap. Lap code 00 shows it from the next cycle on, even after the live time changes.
- R3: The history holds four laps. Each capture moves every stored lap one place older and drops the oldest one. Without a capture the stored laps do not change. Captures work whether or not the live time is advancing.
- R4: Lap select codes are 00 for the newest lap, 01 for the second newest, 11 for the third newest and 10 for the fourth newest.
- R5: View input 1 shows the live time. View input 0 shows the lap chosen by the lap select code.
- R6: The range codes pick the shown fields: 00 gives seconds and hundredths, 01 gives minutes and seconds, 10 gives hours and minutes, and 11 gives days and hours. `digits_o[15:12]` carries the tens digit of the upper field and `digits_o[3:0]` the units digit of the lower field. `live_time_i` packs the digits from days tens at [39:36] down to hundredths units at [3:0], four bits each.
- R7: The view, lap select and range inputs are registered once. A change becomes visible on `digits_o` only after the next rising clock edge.
- R8: Synchronous reset clears the history. A lap slot that has never been written reads as all-zero time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (100 Hz time base) |
| rst | input | 1 | Synchronous active-high reset |
| rec_btn_i | input | 1 | Record pushbutton level |
| view_live_i | input | 1 | 1 shows the live time, 0 shows a stored lap |
| lap_sel_i | input | 2 | Selects the stored lap (newest-first, Gray-ordered codes) |
| range_sel_i | input | 2 | Selects which pair of time fields is shown |
| live_time_i | input | 40 | Live time, ten BCD digits |
| capture_o | output | 1 | One-cycle capture pulse |
| digits_o | output | 16 | Four display digits, most significant first |

## Verification
The bench makes five captures and walks all four lap codes under every range code. A history that does not drop its oldest entry, or a decoder that reads the codes as plain binary, swaps the third and fourth laps or shows the first capture again. It also reads slots that have not been written after only two captures, and a design that leaves them uninitialised shows stale or unknown digits there. The button is held down for several cycles and then released, so an edge detector that fires on a level or on the falling edge produces extra pulses. Right after a selector changes, the bench checks that the old window is still shown, which catches a selector path that skips its register.

// File: rtl/lap_view_pkg.sv
package lap_view_pkg;

    localparam int DIGIT_W      = 4;
    localparam int NUM_DIGITS   = 10;
    localparam int FIELD_DIGITS = 2;
    localparam int WIN_FIELDS   = 2;
    localparam int HIST_DEPTH   = 4;

    localparam int TIME_W     = DIGIT_W * NUM_DIGITS;
    localparam int FIELD_W    = DIGIT_W * FIELD_DIGITS;
    localparam int WIN_W      = FIELD_W * WIN_FIELDS;
    localparam int NUM_FIELDS = NUM_DIGITS / FIELD_DIGITS;
    localparam int SEL_W      = $clog2(HIST_DEPTH);
    localparam int RANGE_W    = $clog2(NUM_FIELDS - WIN_FIELDS + 1);

    typedef logic [TIME_W-1:0]  time_t;
    typedef logic [WIN_W-1:0]   win_t;
    typedef logic [SEL_W-1:0]   lap_code_t;
    typedef logic [RANGE_W-1:0] range_t;

    typedef enum logic {
        VIEW_LAP  = 1'b0,
        VIEW_LIVE = 1'b1
    } view_e;

    typedef struct packed {
        view_e     view;
        lap_code_t lap_code;
        range_t    range;
    } view_cfg_t;

    // Reflected-code lap selector to age index (0 = newest).
    function automatic lap_code_t code_to_age(input lap_code_t code);
        lap_code_t age;
        age[SEL_W-1] = code[SEL_W-1];
        for (int i = SEL_W - 2; i >= 0; i--) begin
            age[i] = age[i+1] ^ code[i];
        end
        return age;
    endfunction

    // Two adjacent fields starting at the field picked by the range code.
    function automatic win_t window_of(input time_t t, input range_t r);
        time_t shifted;
        shifted = t >> (int'(r) * FIELD_W);
        return shifted[WIN_W-1:0];
    endfunction

endpackage

// File: rtl/lap_edge_detect.sv
module lap_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic btn_i,
    output logic pulse_o
);
    logic smp_new_q;
    logic smp_old_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_new_q <= 1'b0;
            smp_old_q <= 1'b0;
        end else begin
            smp_new_q <= btn_i;
            smp_old_q <= smp_new_q;
        end
    end

    assign pulse_o = smp_new_q & ~smp_old_q;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o); // R1

    AST_PULSE_FROM_BUTTON: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> $past(btn_i)); // R1

endmodule

// File: rtl/lap_history.sv
module lap_history
    import lap_view_pkg::*;
#(
    parameter int DEPTH = HIST_DEPTH,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_i,
    input  time_t            live_i,
    input  logic [IDX_W-1:0] rd_age_i,
    output time_t            rd_o
);
    time_t slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)        slot_q[0] <= '0;
                else if (cap_i) slot_q[0] <= live_i;
            end
            AST_NEWEST_LOADED: assert property (@(posedge clk) disable iff (rst)
                cap_i |=> slot_q[0] == $past(live_i)); // R2
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst)        slot_q[i] <= '0;
                else if (cap_i) slot_q[i] <= slot_q[i-1];
            end
            AST_AGE_SHIFT: assert property (@(posedge clk) disable iff (rst)
                cap_i |=> slot_q[i] == $past(slot_q[i-1])); // R3
        end
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
            !cap_i |=> $stable(slot_q[i])); // R3
    end

    assign rd_o = slot_q[rd_age_i];

endmodule

// File: rtl/lap_window_mux.sv
module lap_window_mux
    import lap_view_pkg::*;
(
    input  time_t     live_i,
    input  time_t     lap_i,
    input  view_cfg_t cfg_i,
    output win_t      digits_o
);
    time_t src;

    always_comb begin
        src = (cfg_i.view == VIEW_LIVE) ? live_i : lap_i;
        digits_o = window_of(src, cfg_i.range);
    end

endmodule

// File: rtl/lap_view_top.sv
module lap_view_top
    import lap_view_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rec_btn_i,
    input  logic        view_live_i,
    input  logic [1:0]  lap_sel_i,
    input  logic [1:0]  range_sel_i,
    input  logic [39:0] live_time_i,
    output logic        capture_o,
    output logic [15:0] digits_o
);
    view_cfg_t cfg_q;
    time_t     lap_rd;
    lap_code_t age;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{view: VIEW_LAP, lap_code: '0, range: '0};
        end else begin
            cfg_q.view     <= view_e'(view_live_i);
            cfg_q.lap_code <= lap_sel_i;
            cfg_q.range    <= range_sel_i;
        end
    end

    assign age = code_to_age(cfg_q.lap_code);

    lap_edge_detect u_edge (
        .clk    (clk),
        .rst    (rst),
        .btn_i  (rec_btn_i),
        .pulse_o(capture_o)
    );

    lap_history #(.DEPTH(HIST_DEPTH)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .cap_i   (capture_o),
        .live_i  (live_time_i),
        .rd_age_i(age),
        .rd_o    (lap_rd)
    );

    lap_window_mux u_mux (
        .live_i  (live_time_i),
        .lap_i   (lap_rd),
        .cfg_i   (cfg_q),
        .digits_o(digits_o)
    );

    AST_CFG_REGISTERED: assert property (@(posedge clk) disable iff (rst)
        !$stable(range_sel_i) |=> cfg_q.range == $past(range_sel_i)); // R7

    AST_LIVE_VIEW: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.view == VIEW_LIVE && cfg_q.range == 2'b00) |-> digits_o == live_time_i[15:0]); // R5

endmodule

// File: tb/lap_view_top_test.sv
module lap_view_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rec_btn_i = 1'b0;
    logic        view_live_i = 1'b0;
    logic [1:0]  lap_sel_i = 2'b00;
    logic [1:0]  range_sel_i = 2'b00;
    logic [39:0] live_time_i = '0;
    logic        capture_o;
    logic [15:0] digits_o;

    int checks = 0;
    int fails  = 0;
    logic [39:0] model [4];

    always #10 clk = ~clk;

    lap_view_top uut (
        .clk(clk), .rst(rst), .rec_btn_i(rec_btn_i), .view_live_i(view_live_i),
        .lap_sel_i(lap_sel_i), .range_sel_i(range_sel_i), .live_time_i(live_time_i),
        .capture_o(capture_o), .digits_o(digits_o)
    );

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_win(input logic [39:0] t, input logic [1:0] r);
        case (r)
            2'b00:   return {t[15:12], t[11:8], t[7:4], t[3:0]};
            2'b01:   return {t[23:20], t[19:16], t[15:12], t[11:8]};
            2'b10:   return {t[31:28], t[27:24], t[23:20], t[19:16]};
            default: return {t[39:36], t[35:32], t[31:28], t[27:24]};
        endcase
    endfunction

    function automatic logic [1:0] age_code(input int k);
        case (k)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    // R8: reset clears history, reads zero everywhere
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) model[k] = '0;
        chk("R8 reset capture", {39'd0, capture_o}, 40'd0);
        view_live_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            lap_sel_i = age_code(k);
            range_sel_i = 2'(k);
            @(negedge clk);
            chk("R8 cleared slot", {24'd0, digits_o}, 40'd0);
        end
    endtask

    // R1 R2 R3: one press captures the value present
    task automatic t_press(input logic [39:0] v);
        live_time_i = v;
        rec_btn_i = 1'b1;
        @(negedge clk);
        chk("R1 pulse high", {39'd0, capture_o}, 40'd1);
        @(negedge clk);
        chk("R1 pulse ends", {39'd0, capture_o}, 40'd0);
        repeat (3) @(negedge clk);
        chk("R1 held no pulse", {39'd0, capture_o}, 40'd0);
        rec_btn_i = 1'b0;
        live_time_i = ~v;
        @(negedge clk);
        chk("R1 release no pulse", {39'd0, capture_o}, 40'd0);
        @(negedge clk);
        chk("R1 release no pulse", {39'd0, capture_o}, 40'd0);
        for (int k = 3; k > 0; k--) model[k] = model[k-1];
        model[0] = v;
    endtask

    // R4 R6 R8 R2 R3: every lap code under every range
    task automatic t_history(input int n_valid);
        view_live_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            for (int r = 0; r < 4; r++) begin
                lap_sel_i = age_code(k);
                range_sel_i = 2'(r);
                @(negedge clk);
                chk(k < n_valid ? "R4 R6 lap window" : "R8 unwritten slot",
                    {24'd0, digits_o},
                    {24'd0, (k < n_valid) ? exp_win(model[k], 2'(r)) : 16'd0});
            end
        end
    endtask

    // R5 R6: live view follows the live time
    task automatic t_live();
        view_live_i = 1'b1;
        for (int r = 0; r < 4; r++) begin
            live_time_i = 40'h31_23_59_58_97 ^ 40'(r * 40'h01_01_01_01_01);
            range_sel_i = 2'(r);
            @(negedge clk);
            chk("R5 R6 live window", {24'd0, digits_o}, {24'd0, exp_win(live_time_i, 2'(r))});
        end
        view_live_i = 1'b0;
        lap_sel_i = 2'b00;
        range_sel_i = 2'b00;
        @(negedge clk);
        chk("R5 lap view", {24'd0, digits_o}, {24'd0, exp_win(model[0], 2'b00)});
    endtask

    // R7: selector change waits for the next edge
    task automatic t_latency();
        view_live_i = 1'b1;
        live_time_i = 40'h12_34_56_78_90;
        range_sel_i = 2'b00;
        @(negedge clk);
        range_sel_i = 2'b11;
        view_live_i = 1'b0;
        #1;
        chk("R7 before edge", {24'd0, digits_o}, {24'd0, 16'h7890});
        @(negedge clk);
        chk("R7 after edge", {24'd0, digits_o}, {24'd0, exp_win(model[0], 2'b11)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_press(40'h01_02_03_04_05);
        t_press(40'h11_12_13_14_15);
        t_history(2);
        t_press(40'h21_22_23_24_25);
        t_press(40'h31_19_45_36_67);
        t_press(40'h02_07_58_49_88);
        t_history(4);
        t_live();
        t_latency();
        t_reset();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule